// File: doc/BRIEF.md
# Pin Port with Routed Line Interrupts

This block is a bank of general purpose pins, from 1 to 32 lines, that software controls through a small 32-bit register bus with separate read and write strobes. Software chooses which pins drive and what value they drive, and can read back the level on every pin after it passes through a two-flop synchroniser.

Every line can also raise an interrupt request. Two per-line bits set the condition: a low level, a high level, a falling edge or a rising edge. A mask bit gates the request. An 8-bit routing field picks which of the interrupt outputs the line feeds, or leaves it unconnected. Several lines may feed the same output, which is then the OR of their requests. The interrupt outputs are registered.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the drive-value, drive-enable, mask, polarity and edge registers and every routing field read as zero, `pad_oe` and `pad_out` are zero and no interrupt output is active.
- R2: A write to offset 0x04 sets the driven values on `pad_out`, and a write to offset 0x08 sets `pad_oe`, where a 1 makes the line drive. Bits at or above the line count read back as 0, as does the unused offset 0x18.
- R3: A read of offset 0x00 returns the pin levels after two synchronising flops. A pin change made between clock edges is returned by a read strobed two edges later and not by one strobed one edge later. A write to offset 0x00 has no effect.
- R4: With edge bit (offset 0x14) at 0, a polarity bit (offset 0x10) of 0 requests while the line is low and 1 requests while it is high. The request lasts as long as the level holds.
- R5: With edge bit 1, polarity 0 requests on a falling edge and polarity 1 on a rising edge. Each edge gives one request of exactly one cycle, and the opposite transition gives none.
- R6: A line reaches an interrupt output only while its bit in the mask register (offset 0x0C) is 1. A mask of zero keeps every output low from the next cycle on.
- R7: Routing words start at offset 0x20. Word k holds lines 4k to 4k+3 with line 4k in bits 31:24, line 4k+1 in 23:16, line 4k+2 in 15:8 and line 4k+3 in 7:0. A field value v below the number of outputs sends the line to `irq_out[v]`.
- R8: A routing field at or above the number of interrupt outputs leaves the line unrouted, and no output responds to it.
- R9: Lines routed to the same output are ORed. A level change on a pin between edges shows on `irq_out` after the third following rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NLINES | Pin levels from the pads |
| pad_out | output | NLINES | Values to drive on the pins |
| pad_oe | output | NLINES | Per-line drive enable, 1 = drive |
| irq_out | output | NIRQ | Registered interrupt outputs |

## Verification
A stored polarity, edge or mask bit that is wrong shows up on the interrupt outputs on the third edge after a pin change, either as a missing request or as an extra one. A misplaced routing byte sends a request to the wrong output in that same cycle, and the routing readback shows it on the next read. A fault in the edge history makes a pulse last two cycles or appear on the wrong transition, and the bench sees this one cycle after the expected pulse. A broken synchroniser is caught by reading the data register one edge too early and then on time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int MAX_LINES = 32;
    localparam int FIELD_W   = 8;

    localparam logic [7:0] OFF_DATA = 8'h00;
    localparam logic [7:0] OFF_OUT  = 8'h04;
    localparam logic [7:0] OFF_DIR  = 8'h08;
    localparam logic [7:0] OFF_MASK = 8'h0C;
    localparam logic [7:0] OFF_POL  = 8'h10;
    localparam logic [7:0] OFF_EDGE = 8'h14;
    localparam logic [7:0] OFF_MAP0 = 8'h20;

    typedef struct packed {
        logic [31:0]                             drv;
        logic [31:0]                             oe;
        logic [31:0]                             msk;
        logic [31:0]                             pol;
        logic [31:0]                             edg;
        logic [MAX_LINES-1:0][FIELD_W-1:0]       route;
        logic [31:0]                             rdata;
    } port_regs_t;

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } line_hist_t;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [31:0]                     wdata,
    input  logic [NLINES-1:0]               sample,
    output logic [31:0]                     rdata,
    output logic [NLINES-1:0]               drv_o,
    output logic [NLINES-1:0]               oe_o,
    output logic [NLINES-1:0]               msk_o,
    output logic [NLINES-1:0]               pol_o,
    output logic [NLINES-1:0]               edg_o,
    output logic [NLINES-1:0][FIELD_W-1:0]  route_o
);

    localparam int          NWORDS    = (NLINES + 3) / 4;
    localparam logic [31:0] LINE_MASK = 32'((64'd1 << NLINES) - 64'd1);

    port_regs_t q, d;

    logic [ADDR_W-1:0] map_off;
    logic [ADDR_W-1:0] word_idx;
    logic              map_sel;

    always_comb begin
        logic [31:0] rd;
        d        = q;
        map_off  = addr - ADDR_W'(OFF_MAP0);
        word_idx = map_off >> 2;
        map_sel  = (addr >= ADDR_W'(OFF_MAP0)) && (addr[1:0] == 2'b00) &&
                   (int'(word_idx) < NWORDS);

        if (wr_en) begin
            if (addr == ADDR_W'(OFF_OUT))       d.drv = wdata & LINE_MASK;
            else if (addr == ADDR_W'(OFF_DIR))  d.oe  = wdata & LINE_MASK;
            else if (addr == ADDR_W'(OFF_MASK)) d.msk = wdata & LINE_MASK;
            else if (addr == ADDR_W'(OFF_POL))  d.pol = wdata & LINE_MASK;
            else if (addr == ADDR_W'(OFF_EDGE)) d.edg = wdata & LINE_MASK;
            else if (map_sel) begin
                for (int l = 0; l < MAX_LINES; l++) begin
                    if ((l < NLINES) && ((l / 4) == int'(word_idx)))
                        d.route[l] = wdata[31-8*(l%4) -: 8];
                end
            end
        end

        rd = '0;
        if (addr == ADDR_W'(OFF_DATA))      rd = 32'(sample);
        else if (addr == ADDR_W'(OFF_OUT))  rd = q.drv;
        else if (addr == ADDR_W'(OFF_DIR))  rd = q.oe;
        else if (addr == ADDR_W'(OFF_MASK)) rd = q.msk;
        else if (addr == ADDR_W'(OFF_POL))  rd = q.pol;
        else if (addr == ADDR_W'(OFF_EDGE)) rd = q.edg;
        else if (map_sel) begin
            for (int l = 0; l < MAX_LINES; l++) begin
                if ((l / 4) == int'(word_idx))
                    rd[31-8*(l%4) -: 8] = q.route[l];
            end
        end
        if (rd_en) d.rdata = rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata   = q.rdata;
    assign drv_o   = q.drv[NLINES-1:0];
    assign oe_o    = q.oe[NLINES-1:0];
    assign msk_o   = q.msk[NLINES-1:0];
    assign pol_o   = q.pol[NLINES-1:0];
    assign edg_o   = q.edg[NLINES-1:0];
    assign route_o = q.route[NLINES-1:0];

    // R2: the unused offset never returns data
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8'h18)) |=> (rdata == 32'd0));

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    input  logic pol,
    input  logic edg,
    output logic sample,
    output logic req
);

    line_hist_t q, d;

    always_comb begin
        d.meta   = pad;
        d.stable = q.meta;
        d.prev   = q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sample = q.stable;

    always_comb begin
        if (edg) req = pol ? (q.stable & ~q.prev) : (~q.stable & q.prev);
        else     req = pol ? q.stable : ~q.stable;
    end

    // R5: an edge request never lasts two cycles under a fixed setting
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (edg && req) |=> !(edg && req && $stable(pol)));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NLINES-1:0]               req,
    input  logic [NLINES-1:0]               msk,
    input  logic [NLINES-1:0][FIELD_W-1:0]  route,
    output logic [NIRQ-1:0]                 irq
);

    logic [NIRQ-1:0] irq_d, irq_q;

    always_comb begin
        irq_d = '0;
        for (int l = 0; l < NLINES; l++) begin
            for (int k = 0; k < NIRQ; k++) begin
                if (msk[l] && req[l] && (route[l] == FIELD_W'(k)))
                    irq_d[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R6: with every line masked the outputs go quiet on the next cycle
    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0) |=> (irq == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NIRQ-1:0]   irq_out
);

    logic [NLINES-1:0]              sample;
    logic [NLINES-1:0]              req;
    logic [NLINES-1:0]              msk;
    logic [NLINES-1:0]              pol;
    logic [NLINES-1:0]              edg;
    logic [NLINES-1:0][FIELD_W-1:0] route;

    gpio_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .sample  (sample),
        .rdata   (bus_rdata),
        .drv_o   (pad_out),
        .oe_o    (pad_oe),
        .msk_o   (msk),
        .pol_o   (pol),
        .edg_o   (edg),
        .route_o (route)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        gpio_line_detect i_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pad    (pad_in[g]),
            .pol    (pol[g]),
            .edg    (edg[g]),
            .sample (sample[g]),
            .req    (req[g])
        );
    end

    gpio_irq_route #(.NLINES(NLINES), .NIRQ(NIRQ)) i_route (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .msk   (msk),
        .route (route),
        .irq   (irq_out)
    );

    // R2: a drive-enable write reaches the pads on the following cycle
    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DIR)) |=> (pad_oe == $past(bus_wdata[NLINES-1:0])));

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

    localparam int NL = 6;
    localparam int NQ = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out;
    logic [NL-1:0] pad_oe;
    logic [NQ-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] fld [NL];

    always #5 clk = ~clk;

    gpio_irq_port #(.NLINES(NL), .NIRQ(NQ), .ADDR_W(8)) i_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // lines 0..3 in word 0 (line 0 in top byte), lines 4..5 in word 1
    task automatic put_map();
        wr(8'h20, {fld[0], fld[1], fld[2], fld[3]});
        wr(8'h24, {fld[4], fld[5], 16'h0000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 pad_out", 32'(pad_out), 0);
        check("R1 irq_out", 32'(irq_out), 0);
        for (int a = 1; a < 6; a++) begin
            rd(8'(4 * a), v);
            check("R1 register", v, 0);
        end
        rd(8'h20, v); check("R1 map word 0", v, 0);
        rd(8'h24, v); check("R1 map word 1", v, 0);

        // R2 drive value and drive enable
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0015 :
                  (p == 2) ? 32'hA5A5_A52A : 32'h0000_0000;
            wr(8'h04, pat);
            check("R2 pad_out", 32'(pad_out), pat & 32'h3F);
            rd(8'h04, v); check("R2 out readback", v, pat & 32'h3F);
            wr(8'h08, ~pat);
            check("R2 pad_oe", 32'(pad_oe), ~pat & 32'h3F);
            rd(8'h08, v); check("R2 dir readback", v, ~pat & 32'h3F);
        end
        rd(8'h18, v); check("R2 unused offset", v, 0);

        // R3 synchronised data read
        for (int p = 0; p < 64; p += 7) begin
            logic [5:0] prev;
            prev = pad_in;
            @(negedge clk); pad_in = 6'(p);
            rd(8'h00, v); check("R3 too early", v, 32'(prev));
            @(negedge clk); pad_in = 6'(p ^ 6'h3F);
            wait_cyc(1);
            pad_in = 6'(p);
            wait_cyc(2);
            rd(8'h00, v); check("R3 data", v, 32'(p));
        end
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R3 data write ignored", v, 32'(pad_in));

        // R4 R5 R9 per line, per mode
        for (int l = 0; l < NL; l++) begin
            for (int m = 0; m < 4; m++) begin
                logic pl, ed;
                logic [NQ-1:0] exp;
                pl = m[0]; ed = m[1];
                exp = NQ'(1 << (l % NQ));
                wr(8'h0C, 0);
                pad_in = pl ? 6'h00 : 6'h3F;
                wait_cyc(4);
                wr(8'h10, pl ? 32'h3F : 0);
                wr(8'h14, ed ? 32'h3F : 0);
                for (int k = 0; k < NL; k++) fld[k] = (k == l) ? 8'(l % NQ) : 8'd3;
                put_map();
                wr(8'h0C, 32'(1 << l));
                wait_cyc(2);
                check("R4 idle quiet", 32'(irq_out), 0);
                pad_in[l] = pl;
                wait_cyc(2);
                check("R9 not before third edge", 32'(irq_out), 0);
                wait_cyc(1);
                check(ed ? "R5 edge request" : "R4 level request", 32'(irq_out), 32'(exp));
                wait_cyc(1);
                check(ed ? "R5 one-cycle pulse" : "R4 level held", 32'(irq_out), ed ? 0 : 32'(exp));
                pad_in[l] = ~pl;
                wait_cyc(3);
                check(ed ? "R5 opposite edge silent" : "R4 level released", 32'(irq_out), 0);
                wait_cyc(1);
                check("R5 stays quiet", 32'(irq_out), 0);
            end
        end

        // R6 mask gating, level high, all lines to output 0
        wr(8'h0C, 0);
        wr(8'h10, 32'h3F);
        wr(8'h14, 0);
        for (int k = 0; k < NL; k++) fld[k] = 8'd0;
        put_map();
        pad_in = 6'h3F;
        wait_cyc(4);
        check("R6 all masked", 32'(irq_out), 0);
        for (int l = 0; l < NL; l++) begin
            wr(8'h0C, 32'(1 << l));
            @(negedge clk);
            check("R6 unmasked line", 32'(irq_out), 1);
            wr(8'h0C, 0);
            @(negedge clk);
            check("R6 masked again", 32'(irq_out), 0);
        end
        pad_in = 6'h00;
        wait_cyc(4);

        // R7 R8 routing sweep
        wr(8'h0C, 32'h3F);
        for (int l = 0; l < NL; l++) begin
            for (int f = 0; f < 5; f++) begin
                logic [7:0] fv;
                fv = (f == 4) ? 8'd200 : 8'(f);
                for (int k = 0; k < NL; k++) fld[k] = (k == l) ? fv : 8'd3;
                put_map();
                if (l == 5) begin
                    rd(8'h24, v);
                    check("R7 map readback", v, {8'd3, fv, 16'h0000});
                end
                @(negedge clk); pad_in = 6'(1 << l);
                wait_cyc(3);
                if (fv < NQ) check("R7 routed output", 32'(irq_out), 32'(1 << fv));
                else         check("R8 unrouted line", 32'(irq_out), 0);
                pad_in = 0;
                wait_cyc(3);
            end
        end

        // R9 shared output is an OR
        for (int k = 0; k < NL; k++) fld[k] = 8'd3;
        fld[0] = 8'd1; fld[2] = 8'd1; fld[5] = 8'd1; fld[3] = 8'd2;
        put_map();
        rd(8'h20, v); check("R7 map word 0", v, 32'h0103_0102);
        for (int p = 0; p < 64; p++) begin
            logic [NQ-1:0] exp;
            @(negedge clk); pad_in = 6'(p);
            wait_cyc(3);
            exp = '0;
            if (p[0] | p[2] | p[5]) exp[1] = 1'b1;
            if (p[3]) exp[2] = 1'b1;
            check("R9 shared OR", 32'(irq_out), 32'(exp));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule